// File: doc/BRIEF.md
# Wavetable Playback Channel

A single-voice sound source that cycles through a small programmable waveform. Software fills a 64-step table of 6-bit unsigned samples, programs a 12-bit pitch word, and the channel walks the table with a phase accumulator. On every enabled CPU cycle the accumulator grows by the pitch word plus a signed offset from an external modulator.

The current table entry is scaled twice before it leaves the block. The first factor is the external volume gain, capped at 32. The second is a 2-bit master ratio. The result is a registered 12-bit unsigned level for a downstream DAC. The envelope and modulator units sit outside this block and supply only their gain and pitch offset.

A halt control parks the channel on entry 0. A write-enable control opens the table to CPU writes and freezes the output level, while the phase keeps moving.

Top module: `wtbl_channel`

## Requirements
- R1: The table holds 64 entries of 6 bits each. A CPU read of `tbl_addr` is combinational and returns `{2'b01, sample}`. A write (`tbl_we`) lands at `tbl_addr` on the next edge when write-enable is set.
- R2: A table write issued while write-enable is clear has no effect on the stored entry.
- R3: Register writes use `reg_sel`: 0 loads bits 7:0 of the pitch word, 1 loads bits 11:8 from data bits 3:0, and 2 loads the control byte. On each edge with `step_en` high, the 22-bit phase grows by Freq+Mod modulo 2^22. `wave_idx` is phase bits 21:16, so the index wraps from 63 to 0.
- R4: The phase does not move when `step_en` is low, when Freq is zero, or when Freq+Mod is zero or negative.
- R5: Data bit 7 of a `reg_sel`=1 write is the halt flag. While the flag is set, the phase is held at 0, `wave_idx` reads 0, and the output is entry 0 scaled by the volume and the master ratio.
- R6: The effective volume is min(`vol_gain`, 32). The output is the table sample times the effective volume times the master ratio, rounded down.
- R7: Bits 1:0 of the control byte select the master ratio. Code 0 selects 1, code 1 selects 2/3, code 2 selects 1/2 and code 3 selects 2/5.
- R8: Bit 7 of the control byte is write-enable. While it is set, `sample_out` keeps its level and the phase keeps advancing. The output tracks the table again on the edge after the bit clears.
- R9: `sample_out` is registered. A change of `vol_gain` or of the playback state shows on the output one edge later.
- R10: A synchronous reset clears the phase, the pitch word, halt and write-enable, selects the full master ratio, and drives the output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | CPU-cycle enable for the phase accumulator |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 pitch low, 1 pitch high/halt, 2 control |
| reg_wdata | input | 8 | Register write data |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 6 | Table address for CPU read and write |
| tbl_wdata | input | 6 | Table write sample |
| tbl_rdata | output | 8 | Table read data, upper bits 01 |
| vol_gain | input | 6 | Volume gain from the envelope unit |
| mod_ofs | input | 14 | Signed pitch offset from the modulator |
| wave_idx | output | 6 | Current playback index |
| sample_out | output | 12 | Scaled output level |

## Verification
The bench builds the block with its default parameters: a 22-bit phase, a 12-bit pitch word, a 14-bit signed offset, and 6-bit samples and gains. With these widths a step of up to 12286 per cycle is reachable, so an index wrap and an accumulator wrap both occur within a few hundred cycles. Offsets that cancel or exceed the pitch word are also reachable. Gains above the cap of 32 and all four master ratios can be driven on a full-scale sample, which brings every flooring case of the scaler into play.

// File: rtl/wtbl_pkg.sv
package wtbl_pkg;

    // register select codes
    typedef enum logic [1:0] {
        SEL_FREQ_LO = 2'd0,
        SEL_FREQ_HI = 2'd1,
        SEL_CTRL    = 2'd2,
        SEL_SPARE   = 2'd3
    } reg_sel_e;

    // master ratio codes
    typedef enum logic [1:0] {
        MV_FULL       = 2'd0,
        MV_TWO_THIRDS = 2'd1,
        MV_HALF       = 2'd2,
        MV_TWO_FIFTHS = 2'd3
    } mvol_e;

    localparam int HALT_BIT = 7;
    localparam int WEN_BIT  = 7;
    localparam logic [1:0] RD_TAG = 2'b01;

endpackage

// File: rtl/wtbl_regs.sv
module wtbl_regs
    import wtbl_pkg::*;
#(
    parameter int FREQ_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [7:0]        reg_wdata,
    output logic [FREQ_W-1:0] freq,
    output logic              halt,
    output logic              wen,
    output mvol_e             mvol
);

    localparam int HI_W = FREQ_W - 8;

    typedef struct packed {
        logic [FREQ_W-1:0] freq;
        logic              halt;
        logic              wen;
        mvol_e             mvol;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (reg_we) begin
            case (reg_sel_e'(reg_sel))
                SEL_FREQ_LO: st_d.freq[7:0] = reg_wdata;
                SEL_FREQ_HI: begin
                    st_d.freq[FREQ_W-1:8] = reg_wdata[HI_W-1:0];
                    st_d.halt             = reg_wdata[HALT_BIT];
                end
                SEL_CTRL: begin
                    st_d.wen  = reg_wdata[WEN_BIT];
                    st_d.mvol = mvol_e'(reg_wdata[1:0]);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.freq <= '0;
            st_q.halt <= 1'b0;
            st_q.wen  <= 1'b0;
            st_q.mvol <= MV_FULL;
        end else begin
            st_q <= st_d;
        end
    end

    assign freq = st_q.freq;
    assign halt = st_q.halt;
    assign wen  = st_q.wen;
    assign mvol = st_q.mvol;

endmodule

// File: rtl/wtbl_table.sv
module wtbl_table #(
    parameter int SAMPLE_W = 6,
    parameter int IDX_W    = 6
) (
    input  logic                clk,
    input  logic                we,
    input  logic [IDX_W-1:0]    waddr,
    input  logic [SAMPLE_W-1:0] wdata,
    input  logic [IDX_W-1:0]    cpu_addr,
    output logic [SAMPLE_W-1:0] cpu_data,
    input  logic [IDX_W-1:0]    play_addr,
    output logic [SAMPLE_W-1:0] play_data
);

    localparam int DEPTH = 1 << IDX_W;

    logic [SAMPLE_W-1:0] mem_d [DEPTH];
    logic [SAMPLE_W-1:0] mem_q [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        always_comb begin
            mem_d[e] = mem_q[e];
            if (we && (waddr == IDX_W'(e))) begin
                mem_d[e] = wdata;
            end
        end

        always_ff @(posedge clk) begin
            mem_q[e] <= mem_d[e];
        end
    end

    assign cpu_data  = mem_q[cpu_addr];
    assign play_data = mem_q[play_addr];

endmodule

// File: rtl/wtbl_phase.sv
module wtbl_phase #(
    parameter int PHASE_W = 22,
    parameter int FREQ_W  = 12,
    parameter int MOD_W   = 14,
    parameter int IDX_W   = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    step_en,
    input  logic                    halt,
    input  logic [FREQ_W-1:0]       freq,
    input  logic signed [MOD_W-1:0] mod_ofs,
    output logic [IDX_W-1:0]        idx,
    output logic [PHASE_W-1:0]      phase
);

    localparam int WIDE_W = (FREQ_W + 1 > MOD_W) ? FREQ_W + 1 : MOD_W;
    localparam int SUM_W  = WIDE_W + 1;

    typedef struct packed {
        logic [PHASE_W-1:0] phase;
    } ph_t;

    ph_t ph_d, ph_q;

    logic signed [SUM_W-1:0] freq_s;
    logic signed [SUM_W-1:0] mod_s;
    logic signed [SUM_W-1:0] sum;
    logic                    sum_pos;
    logic                    advance;
    logic [PHASE_W-1:0]      inc;

    always_comb begin
        freq_s  = {{(SUM_W - FREQ_W){1'b0}}, freq};
        mod_s   = {{(SUM_W - MOD_W){mod_ofs[MOD_W-1]}}, mod_ofs};
        sum     = freq_s + mod_s;
        sum_pos = !sum[SUM_W-1] && (sum != '0);
        advance = step_en && !halt && (freq != '0) && sum_pos;
        inc     = {{(PHASE_W - SUM_W){1'b0}}, sum};

        ph_d = ph_q;
        if (halt) begin
            ph_d.phase = '0;
        end else if (advance) begin
            ph_d.phase = ph_q.phase + inc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q.phase <= '0;
        end else begin
            ph_q <= ph_d;
        end
    end

    assign idx   = halt ? '0 : ph_q.phase[PHASE_W-1 -: IDX_W];
    assign phase = ph_q.phase;

endmodule

// File: rtl/wtbl_mixer.sv
module wtbl_mixer
    import wtbl_pkg::*;
#(
    parameter int SAMPLE_W = 6,
    parameter int VOL_W    = 6,
    parameter int VOL_CAP  = 32,
    parameter int OUT_W    = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hold,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [VOL_W-1:0]    vol_gain,
    input  mvol_e               mvol,
    output logic [OUT_W-1:0]    level
);

    localparam int PROD_W = SAMPLE_W + VOL_W;
    localparam int EXT_W  = PROD_W + 2;
    localparam logic [VOL_W-1:0] CAP = VOL_W'(VOL_CAP);

    typedef struct packed {
        logic [OUT_W-1:0] level;
    } mix_t;

    mix_t mx_d, mx_q;

    logic [VOL_W-1:0]  eff;
    logic [PROD_W-1:0] prod;
    logic [EXT_W-1:0]  p_ext;
    logic [EXT_W-1:0]  scaled;

    always_comb begin
        eff   = (vol_gain > CAP) ? CAP : vol_gain;
        prod  = PROD_W'(sample) * PROD_W'(eff);
        p_ext = EXT_W'(prod);
        case (mvol)
            MV_TWO_THIRDS: scaled = (p_ext << 1) / EXT_W'(3);
            MV_HALF:       scaled = p_ext >> 1;
            MV_TWO_FIFTHS: scaled = (p_ext << 1) / EXT_W'(5);
            default:       scaled = p_ext;
        endcase

        mx_d = mx_q;
        if (!hold) begin
            mx_d.level = OUT_W'(scaled);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mx_q.level <= '0;
        end else begin
            mx_q <= mx_d;
        end
    end

    assign level = mx_q.level;

endmodule

// File: rtl/wtbl_channel.sv
module wtbl_channel
    import wtbl_pkg::*;
#(
    parameter int SAMPLE_W = 6,
    parameter int IDX_W    = 6,
    parameter int FREQ_W   = 12,
    parameter int MOD_W    = 14,
    parameter int PHASE_W  = 22,
    parameter int VOL_W    = 6,
    parameter int VOL_CAP  = 32,
    parameter int OUT_W    = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    step_en,
    input  logic                    reg_we,
    input  logic [1:0]              reg_sel,
    input  logic [7:0]              reg_wdata,
    input  logic                    tbl_we,
    input  logic [IDX_W-1:0]        tbl_addr,
    input  logic [SAMPLE_W-1:0]     tbl_wdata,
    output logic [SAMPLE_W+1:0]     tbl_rdata,
    input  logic [VOL_W-1:0]        vol_gain,
    input  logic signed [MOD_W-1:0] mod_ofs,
    output logic [IDX_W-1:0]        wave_idx,
    output logic [OUT_W-1:0]        sample_out
);

    logic [FREQ_W-1:0]   freq_w;
    logic                halt_w;
    logic                wen_w;
    mvol_e               mvol_w;
    logic [PHASE_W-1:0]  phase_w;
    logic [SAMPLE_W-1:0] cpu_smp;
    logic [SAMPLE_W-1:0] play_smp;
    logic                tbl_wr_ok;

    assign tbl_wr_ok = tbl_we && wen_w;

    wtbl_regs #(
        .FREQ_W (FREQ_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .freq      (freq_w),
        .halt      (halt_w),
        .wen       (wen_w),
        .mvol      (mvol_w)
    );

    wtbl_table #(
        .SAMPLE_W (SAMPLE_W),
        .IDX_W    (IDX_W)
    ) u_table (
        .clk       (clk),
        .we        (tbl_wr_ok),
        .waddr     (tbl_addr),
        .wdata     (tbl_wdata),
        .cpu_addr  (tbl_addr),
        .cpu_data  (cpu_smp),
        .play_addr (wave_idx),
        .play_data (play_smp)
    );

    wtbl_phase #(
        .PHASE_W (PHASE_W),
        .FREQ_W  (FREQ_W),
        .MOD_W   (MOD_W),
        .IDX_W   (IDX_W)
    ) u_phase (
        .clk     (clk),
        .rst     (rst),
        .step_en (step_en),
        .halt    (halt_w),
        .freq    (freq_w),
        .mod_ofs (mod_ofs),
        .idx     (wave_idx),
        .phase   (phase_w)
    );

    wtbl_mixer #(
        .SAMPLE_W (SAMPLE_W),
        .VOL_W    (VOL_W),
        .VOL_CAP  (VOL_CAP),
        .OUT_W    (OUT_W)
    ) u_mixer (
        .clk      (clk),
        .rst      (rst),
        .hold     (wen_w),
        .sample   (play_smp),
        .vol_gain (vol_gain),
        .mvol     (mvol_w),
        .level    (sample_out)
    );

    assign tbl_rdata = {RD_TAG, cpu_smp};

endmodule

// File: rtl/wtbl_channel_chk.sv
module wtbl_channel_chk #(
    parameter int PHASE_W = 22,
    parameter int FREQ_W  = 12,
    parameter int OUT_W   = 12,
    parameter int OUT_MAX = 2016
) (
    input logic               clk,
    input logic               rst,
    input logic               step_en,
    input logic               halt,
    input logic               wen,
    input logic [FREQ_W-1:0]  freq,
    input logic [PHASE_W-1:0] phase,
    input logic [OUT_W-1:0]   sample_out
);

    // R8
    hold_level_chk: assert property (@(posedge clk) disable iff (rst)
        wen |=> $stable(sample_out));

    // R5
    halt_phase_chk: assert property (@(posedge clk) disable iff (rst)
        halt |=> (phase == '0));

    // R4
    zero_freq_chk: assert property (@(posedge clk) disable iff (rst)
        (!halt && (freq == '0)) |=> $stable(phase));

    // R4
    no_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!halt && !step_en) |=> $stable(phase));

    // R6
    level_cap_chk: assert property (@(posedge clk) disable iff (rst)
        sample_out <= OUT_W'(OUT_MAX));

endmodule

bind wtbl_channel wtbl_channel_chk #(
    .PHASE_W (PHASE_W),
    .FREQ_W  (FREQ_W),
    .OUT_W   (OUT_W),
    .OUT_MAX (((1 << SAMPLE_W) - 1) * VOL_CAP)
) i_chk (
    .clk        (clk),
    .rst        (rst),
    .step_en    (step_en),
    .halt       (halt_w),
    .wen        (wen_w),
    .freq       (freq_w),
    .phase      (phase_w),
    .sample_out (sample_out)
);

// File: tb/test_wtbl_channel.sv
module test_wtbl_channel;

    localparam logic [1:0] S_FLO  = 2'd0;
    localparam logic [1:0] S_FHI  = 2'd1;
    localparam logic [1:0] S_CTRL = 2'd2;

    // {freq[11:0], mod[13:0], cycles[15:0], expected index[5:0]}
    localparam logic [47:0] VEC [0:7] = '{
        {12'h800, 14'h0000, 16'd100,  6'd3},
        {12'hFFF, 14'h0000, 16'd64,   6'd3},
        {12'hFFF, 14'h0001, 16'd64,   6'd4},
        {12'h100, 14'h3F00, 16'd50,   6'd0},
        {12'h100, 14'h3E00, 16'd50,   6'd0},
        {12'h000, 14'h0400, 16'd50,   6'd0},
        {12'hFFF, 14'h1FFF, 16'd400,  6'd10},
        {12'h010, 14'h00F0, 16'd1000, 6'd3}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step_en = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic        tbl_we = 1'b0;
    logic [5:0]  tbl_addr = 6'd0;
    logic [5:0]  tbl_wdata = 6'd0;
    logic [7:0]  tbl_rdata;
    logic [5:0]  vol_gain = 6'd0;
    logic signed [13:0] mod_ofs = 14'sd0;
    logic [5:0]  wave_idx;
    logic [11:0] sample_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [11:0] vf;
    logic [13:0] vm;
    logic [15:0] vn;
    logic [5:0]  ve;
    int held;

    always #10 clk = ~clk;

    wtbl_channel i_wtbl_channel (
        .clk        (clk),
        .rst        (rst),
        .step_en    (step_en),
        .reg_we     (reg_we),
        .reg_sel    (reg_sel),
        .reg_wdata  (reg_wdata),
        .tbl_we     (tbl_we),
        .tbl_addr   (tbl_addr),
        .tbl_wdata  (tbl_wdata),
        .tbl_rdata  (tbl_rdata),
        .vol_gain   (vol_gain),
        .mod_ofs    (mod_ofs),
        .wave_idx   (wave_idx),
        .sample_out (sample_out)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [7:0] data);
        reg_we = 1'b1;
        reg_sel = sel;
        reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic tbl_write(input logic [5:0] addr, input logic [5:0] data);
        tbl_we = 1'b1;
        tbl_addr = addr;
        tbl_wdata = data;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic tbl_read(input logic [5:0] addr, output int val);
        tbl_addr = addr;
        #1;
        val = int'(tbl_rdata);
    endtask

    initial begin
        int rd;
        cyc(3);
        rst = 1'b0;
        cyc(1);

        // R10: reset state
        check("R10 index after reset", int'(wave_idx), 0);
        check("R10 output after reset", int'(sample_out), 0);

        // R1: write accepted with write-enable set, read tag 01
        reg_write(S_CTRL, 8'h80);
        tbl_write(6'd3, 6'h0A);
        tbl_read(6'd3, rd);
        check("R1 table read after enabled write", rd, 8'h4A);

        // R2: write with write-enable clear is ignored
        reg_write(S_CTRL, 8'h00);
        tbl_write(6'd3, 6'h15);
        tbl_read(6'd3, rd);
        check("R2 protected write ignored", rd, 8'h4A);

        // fill table: entry i = i, entry 0 = 63
        reg_write(S_CTRL, 8'h80);
        for (int i = 0; i < 64; i++) begin
            tbl_write(6'(i), (i == 0) ? 6'd63 : 6'(i));
        end
        reg_write(S_CTRL, 8'h00);
        tbl_read(6'd0, rd);
        check("R1 entry 0 read", rd, 8'h7F);
        tbl_read(6'd63, rd);
        check("R1 last entry read", rd, 8'h7F);

        // R5/R6: halt parks on entry 0, volume cap
        reg_write(S_FHI, 8'h80);
        vol_gain = 6'd63;
        cyc(1);
        check("R6 gain 63 capped, full ratio", int'(sample_out), 2016);
        vol_gain = 6'd20;
        cyc(1);
        check("R6 gain 20", int'(sample_out), 1260);
        vol_gain = 6'd33;
        cyc(1);
        check("R6 gain 33 capped", int'(sample_out), 2016);

        // R7: master ratios
        reg_write(S_CTRL, 8'h01);
        cyc(1);
        check("R7 ratio 2/3", int'(sample_out), 1344);
        reg_write(S_CTRL, 8'h02);
        cyc(1);
        check("R7 ratio 1/2", int'(sample_out), 1008);
        reg_write(S_CTRL, 8'h03);
        cyc(1);
        check("R7 ratio 2/5", int'(sample_out), 806);
        vol_gain = 6'd7;
        cyc(1);
        check("R7 ratio 2/5 floor", int'(sample_out), 176);
        reg_write(S_CTRL, 8'h01);
        cyc(1);
        check("R7 ratio 2/3 floor", int'(sample_out), 294);
        reg_write(S_CTRL, 8'h00);

        // R9: registered output
        vol_gain = 6'd10;
        cyc(1);
        check("R9 settled level", int'(sample_out), 630);
        vol_gain = 6'd20;
        #1;
        check("R9 no change before edge", int'(sample_out), 630);
        cyc(1);
        check("R9 change after edge", int'(sample_out), 1260);

        // R3/R4: stimulus table
        for (int v = 0; v < 8; v++) begin
            {vf, vm, vn, ve} = VEC[v];
            reg_write(S_FHI, 8'h80);
            mod_ofs = vm;
            reg_write(S_FLO, vf[7:0]);
            reg_write(S_FHI, {4'h0, vf[11:8]});
            step_en = 1'b1;
            cyc(int'(vn));
            step_en = 1'b0;
            check((v >= 3 && v <= 5) ? "R4 blocked step vector" : "R3 step vector",
                  int'(wave_idx), int'(ve));
        end

        // R5: halt while running
        vol_gain = 6'd10;
        reg_write(S_FHI, 8'h80);
        check("R5 index forced to 0", int'(wave_idx), 0);
        cyc(1);
        check("R5 output entry 0", int'(sample_out), 630);
        step_en = 1'b1;
        cyc(10);
        step_en = 1'b0;
        check("R5 no motion while halted", int'(wave_idx), 0);

        // R8: hold with phase advance
        mod_ofs = 14'sd0;
        reg_write(S_FLO, 8'h00);
        reg_write(S_FHI, 8'h08);
        step_en = 1'b1;
        cyc(70);
        step_en = 1'b0;
        check("R3 index after 70 steps", int'(wave_idx), 2);
        cyc(1);
        check("R6 level at entry 2", int'(sample_out), 20);
        reg_write(S_CTRL, 8'h80);
        held = int'(sample_out);
        vol_gain = 6'd40;
        step_en = 1'b1;
        cyc(100);
        step_en = 1'b0;
        check("R8 phase advances while held", int'(wave_idx), 5);
        check("R8 level held", int'(sample_out), held);
        reg_write(S_CTRL, 8'h00);
        cyc(1);
        check("R8 level after release", int'(sample_out), 160);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R3 watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule